// File: doc/BRIEF.md
# Streaming-Store Write-Combining Buffer

This block gathers non-temporal stores aimed at one aligned 64-byte line and hands the result to a memory controller as write transactions. Stores arrive one aligned word at a time, with per-byte enables. The buffer keeps one valid bit per byte of the line. It never reads memory, so bytes that no store has written stay unknown to it.

When the buffer drains, a line with every byte written leaves as a single full-line write that needs no merge. A line with gaps leaves as one or two masked transactions, each confined to one 32-byte half, so the controller can merge the written bytes with what it already holds. A drain starts on an explicit flush request, which also covers early flushes such as an interrupt or a context switch. A drain also starts when a store arrives for a different line than the one held. The output uses a valid/ready handshake, and the store port stalls until the drain is over.

Top module: `write_combine_buf`

## Requirements
- R1: After reset `tx_valid` is low, `st_ready` is high, and the buffer holds no written bytes.
- R2: An accepted store (`st_valid && st_ready`) writes byte j of `st_data` (bits 8j+7:8j) into line byte `st_addr[5:3]*8 + j` for every j with `st_be[j]` set, and marks that byte valid. A later store to a valid byte replaces its data. `st_addr[2:0]` must be zero.
- R3: A drain of a line with all 64 bytes valid emits exactly one transaction with `tx_full`=1, `tx_mask` all ones, and `tx_addr` equal to the line base. Line byte i is carried in `tx_data[8i+7:8i]`.
- R4: A drain of a partly written line emits a masked transaction (`tx_full`=0) for each 32-byte half that holds at least one valid byte, and for no other half. For the lower half, `tx_addr` is the line base and the mask is confined to bits 31:0. For the upper half, `tx_addr` is the line base + 32 and the mask is confined to bits 63:32. Each mask equals that half's valid bits, and the data under set mask bits equals the stored bytes.
- R5: When both halves are sent, the lower-half transaction is emitted before the upper-half one.
- R6: A flush request while no byte is valid emits no transaction.
- R7: A store to a different line than the buffered, non-empty line is not accepted at first. The buffered line drains, and only then is the store accepted as the first store of the new line.
- R8: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_addr`, `tx_mask`, `tx_full` and `tx_data` hold their values.
- R9: `st_ready` is low in every cycle in which `tx_valid` is high.
- R10: When the last transaction of a drain is accepted, every valid bit clears and the buffer returns to idle. A flush issued right after that emits nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| st_valid | input | 1 | Store request present |
| st_ready | output | 1 | Store accepted this cycle when valid |
| st_addr | input | 32 | Byte address of the store, word aligned |
| st_data | input | 64 | Store data, byte j in bits 8j+7:8j |
| st_be | input | 8 | Per-byte write enables |
| flush_req | input | 1 | Request to drain the buffered line |
| tx_valid | output | 1 | Transaction present |
| tx_ready | input | 1 | Controller accepts the transaction |
| tx_addr | output | 32 | Start address: line base, or line base + 32 for the upper half |
| tx_data | output | 512 | Line data, byte i in bits 8i+7:8i |
| tx_mask | output | 64 | Per-byte mask of the bytes that are meaningful |
| tx_full | output | 1 | Full-line write with no merge needed |

## Verification
The embedded properties assume that every store address is word aligned. They also assume that the controller's `tx_ready` is free to toggle at any time, while the store side holds a request until it is taken. The bench drives only aligned addresses and holds each store until it sees `st_ready`. It keeps `flush_req` to single-cycle pulses, and it varies `tx_ready` both as always-high and as a one-in-three pattern. The sweeps cover every word slot under several enable patterns, full and split lines, and line changes. A pseudo-random mix over three lines stays within the same assumptions.

// File: rtl/wcb_pkg.sv
// Shared types for the write-combining buffer.
// Assumes nothing beyond being compiled before the modules that use it.
package wcb_pkg;
    // Drain sequencer state: filling, or sending one kind of transaction.
    typedef enum logic [1:0] {
        WCB_FILL      = 2'd0,
        WCB_SEND_FULL = 2'd1,
        WCB_SEND_LO   = 2'd2,
        WCB_SEND_HI   = 2'd3
    } wcb_state_e;
endpackage

// File: rtl/wcb_line_store.sv
// Line storage: data bytes, per-byte valid mask and the line tag.
// Merges word stores under byte enables and summarises the mask per half.
// Assumes wr_en and clear are never high together and that wr_tag only
// matters while the buffer is empty.
module wcb_line_store #(
    parameter int LINE_BYTES = 64,
    parameter int WORD_BYTES = 8,
    parameter int TAG_W      = 26,
    localparam int WORDS     = LINE_BYTES / WORD_BYTES,
    localparam int IDX_W     = $clog2(WORDS),
    localparam int HALF      = LINE_BYTES / 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [TAG_W-1:0]        wr_tag,
    input  logic [IDX_W-1:0]        wr_idx,
    input  logic [WORD_BYTES*8-1:0] wr_data,
    input  logic [WORD_BYTES-1:0]   wr_be,
    input  logic                    clear,
    output logic [LINE_BYTES*8-1:0] line_data,
    output logic [LINE_BYTES-1:0]   line_mask,
    output logic [TAG_W-1:0]        line_tag,
    output logic                    is_empty,
    output logic                    is_full,
    output logic                    lo_any,
    output logic                    hi_any
);
    logic [LINE_BYTES*8-1:0] data_q;
    logic [LINE_BYTES-1:0]   mask_q;
    logic [TAG_W-1:0]        tag_q;
    logic [LINE_BYTES-1:0]   hit;
    logic [LINE_BYTES*8-1:0] wdata_rep;

    // Replicate the store word across every slot of the line.
    assign wdata_rep = {WORDS{wr_data}};

    // Per-byte write strobes: the addressed slot and the byte enable.
    for (genvar gw = 0; gw < WORDS; gw++) begin : g_slot
        localparam logic [IDX_W-1:0] SLOT = gw;
        for (genvar gb = 0; gb < WORD_BYTES; gb++) begin : g_byte
            assign hit[gw*WORD_BYTES+gb] = wr_en && (wr_idx == SLOT) && wr_be[gb];
        end
    end

    // Byte data and valid bits: merge on write, drop valids on clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            mask_q <= '0;
        end else if (clear) begin
            mask_q <= '0;
        end else begin
            for (int k = 0; k < LINE_BYTES; k++) begin
                if (hit[k]) begin
                    data_q[k*8 +: 8] <= wdata_rep[k*8 +: 8];
                    mask_q[k]        <= 1'b1;
                end
            end
        end
    end

    // Line tag: captured by the first store into an empty buffer.
    always_ff @(posedge clk) begin
        if (!rst_n)                    tag_q <= '0;
        else if (wr_en && ~|mask_q)    tag_q <= wr_tag;
    end

    assign line_data = data_q;
    assign line_mask = mask_q;
    assign line_tag  = tag_q;
    assign is_empty  = ~|mask_q;
    assign is_full   = &mask_q;
    assign lo_any    = |mask_q[HALF-1:0];
    assign hi_any    = |mask_q[LINE_BYTES-1:HALF];

    // A store with any enabled byte leaves the buffer non-empty.
    assert_store_marks_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && |wr_be) |=> !is_empty);

    // A clear always leaves every valid bit low.
    assert_clear_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> is_empty);
endmodule

// File: rtl/wcb_drain_ctrl.sv
// Drain sequencer: picks a full-line write or one or two half-line masked
// writes, walks them through the valid/ready handshake, then clears the line.
// Assumes start is raised only while filling with a non-empty buffer.
module wcb_drain_ctrl
    import wcb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       is_full,
    input  logic       lo_any,
    input  logic       hi_any,
    input  logic       tx_ready,
    output wcb_state_e state,
    output logic       tx_valid,
    output logic       tx_full,
    output logic       tx_upper,
    output logic       clear
);
    wcb_state_e state_q, state_d;

    // Next-state choice and the clear strobe on the last accepted transaction.
    always_comb begin
        state_d = state_q;
        clear   = 1'b0;
        unique case (state_q)
            WCB_FILL: begin
                if (start) begin
                    if (is_full)     state_d = WCB_SEND_FULL;
                    else if (lo_any) state_d = WCB_SEND_LO;
                    else             state_d = WCB_SEND_HI;
                end
            end
            WCB_SEND_FULL: begin
                if (tx_ready) begin
                    state_d = WCB_FILL;
                    clear   = 1'b1;
                end
            end
            WCB_SEND_LO: begin
                if (tx_ready) begin
                    if (hi_any) state_d = WCB_SEND_HI;
                    else begin
                        state_d = WCB_FILL;
                        clear   = 1'b1;
                    end
                end
            end
            WCB_SEND_HI: begin
                if (tx_ready) begin
                    state_d = WCB_FILL;
                    clear   = 1'b1;
                end
            end
            default: state_d = WCB_FILL;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= WCB_FILL;
        else        state_q <= state_d;
    end

    assign state    = state_q;
    assign tx_valid = (state_q != WCB_FILL);
    assign tx_full  = (state_q == WCB_SEND_FULL);
    assign tx_upper = (state_q == WCB_SEND_HI);

    // Accepted lower half with upper bytes pending goes straight to the upper half.
    assert_lo_then_hi_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WCB_SEND_LO && tx_ready && hi_any) |=> (state_q == WCB_SEND_HI));

    // A stalled transaction keeps its kind.
    assert_kind_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> $stable(state_q));
endmodule

// File: rtl/write_combine_buf.sv
// Write-combining buffer for streaming stores into one aligned line.
// Accepts aligned word stores with byte enables, drains on a flush request or
// on a store to another line, and emits full-line or half-line masked writes.
// Assumes st_addr is word aligned; the unwritten bytes are never read.
module write_combine_buf
    import wcb_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 64,
    parameter int WORD_BYTES = 8,
    localparam int OFF_W     = $clog2(LINE_BYTES),
    localparam int WOFF_W    = $clog2(WORD_BYTES),
    localparam int IDX_W     = OFF_W - WOFF_W,
    localparam int TAG_W     = ADDR_W - OFF_W,
    localparam int HALF      = LINE_BYTES / 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    st_valid,
    output logic                    st_ready,
    input  logic [ADDR_W-1:0]       st_addr,
    input  logic [WORD_BYTES*8-1:0] st_data,
    input  logic [WORD_BYTES-1:0]   st_be,
    input  logic                    flush_req,
    output logic                    tx_valid,
    input  logic                    tx_ready,
    output logic [ADDR_W-1:0]       tx_addr,
    output logic [LINE_BYTES*8-1:0] tx_data,
    output logic [LINE_BYTES-1:0]   tx_mask,
    output logic                    tx_full
);
    logic [LINE_BYTES*8-1:0] line_data;
    logic [LINE_BYTES-1:0]   line_mask;
    logic [TAG_W-1:0]        line_tag;
    logic                    is_empty, is_full, lo_any, hi_any;
    logic                    clear, tx_upper, start, idle, other_line, wr_en;
    wcb_state_e              state;
    logic [TAG_W-1:0]        st_tag;
    logic [IDX_W-1:0]        st_idx;

    assign st_tag = st_addr[ADDR_W-1:OFF_W];
    assign st_idx = st_addr[OFF_W-1:WOFF_W];

    // Store admission: idle, no flush pending, same line or empty buffer.
    always_comb begin
        idle       = (state == WCB_FILL);
        other_line = !is_empty && (st_tag != line_tag);
        st_ready   = idle && !flush_req && !other_line;
        wr_en      = st_valid && st_ready;
        start      = idle && !is_empty && (flush_req || (st_valid && other_line));
    end

    wcb_line_store #(
        .LINE_BYTES(LINE_BYTES),
        .WORD_BYTES(WORD_BYTES),
        .TAG_W     (TAG_W)
    ) i_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_tag   (st_tag),
        .wr_idx   (st_idx),
        .wr_data  (st_data),
        .wr_be    (st_be),
        .clear    (clear),
        .line_data(line_data),
        .line_mask(line_mask),
        .line_tag (line_tag),
        .is_empty (is_empty),
        .is_full  (is_full),
        .lo_any   (lo_any),
        .hi_any   (hi_any)
    );

    wcb_drain_ctrl i_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .is_full (is_full),
        .lo_any  (lo_any),
        .hi_any  (hi_any),
        .tx_ready(tx_ready),
        .state   (state),
        .tx_valid(tx_valid),
        .tx_full (tx_full),
        .tx_upper(tx_upper),
        .clear   (clear)
    );

    // Transaction fields: start address and the mask for the half being sent.
    always_comb begin
        tx_addr = {line_tag, tx_upper, {(OFF_W-1){1'b0}}};
        tx_data = line_data;
        if (tx_full)       tx_mask = line_mask;
        else if (tx_upper) tx_mask = {line_mask[LINE_BYTES-1:HALF], {HALF{1'b0}}};
        else               tx_mask = {{HALF{1'b0}}, line_mask[HALF-1:0]};
    end

    // Input assumption: stores are word aligned.
    assert_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid |-> (st_addr[WOFF_W-1:0] == '0));

    // Full-line writes carry a complete mask.
    assert_full_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_full) |-> (&tx_mask));

    // Masked writes are non-empty and confined to one half.
    assert_half_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_full) |->
            ((tx_mask != '0) && ((tx_mask[HALF-1:0] == '0) || (tx_mask[LINE_BYTES-1:HALF] == '0))));

    // Flushing an empty buffer starts nothing.
    assert_empty_flush_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_req && !tx_valid && line_mask == '0) |=> !tx_valid);

    // A stalled transaction keeps every field.
    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=>
            (tx_valid && $stable(tx_addr) && $stable(tx_mask) && $stable(tx_data) && $stable(tx_full)));

    // Stores are stalled while a transaction is pending.
    assert_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> !st_ready);

    // The end of a drain leaves the buffer empty.
    assert_drain_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_valid) |-> (line_mask == '0));
endmodule

// File: tb/test_write_combine_buf.sv
// Self-checking bench: directed sweeps plus a pseudo-random mix, compared
// against an arithmetic model of the expected transaction stream.
module test_write_combine_buf;
    localparam int AW = 32;
    localparam int LB = 64;
    localparam int WB = 8;
    localparam int QD = 1024;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           st_valid = 1'b0;
    logic           st_ready;
    logic [AW-1:0]  st_addr = '0;
    logic [WB*8-1:0] st_data = '0;
    logic [WB-1:0]  st_be = '0;
    logic           flush_req = 1'b0;
    logic           tx_valid;
    logic           tx_ready = 1'b1;
    logic [AW-1:0]  tx_addr;
    logic [LB*8-1:0] tx_data;
    logic [LB-1:0]  tx_mask;
    logic           tx_full;

    int total = 0;
    int bad = 0;

    write_combine_buf i_write_combine_buf (
        .clk(clk), .rst_n(rst_n),
        .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr),
        .st_data(st_data), .st_be(st_be), .flush_req(flush_req),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_addr(tx_addr),
        .tx_data(tx_data), .tx_mask(tx_mask), .tx_full(tx_full)
    );

    always #4 clk = ~clk;   // 125 MHz

    // Bench model of the buffer and the queue of expected transactions.
    logic [LB*8-1:0] m_data = '0;
    logic [LB-1:0]   m_mask = '0;
    logic [AW-7:0]   m_tag = '0;
    logic [AW-1:0]   q_addr [QD];
    logic [LB-1:0]   q_mask [QD];
    logic [LB*8-1:0] q_data [QD];
    logic            q_full [QD];
    int wp = 0;
    int rp = 0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic push(input logic [AW-1:0] a, input logic [LB-1:0] m, input bit f);
        q_addr[wp % QD] = a;
        q_mask[wp % QD] = m;
        q_data[wp % QD] = m_data;
        q_full[wp % QD] = f;
        wp++;
    endtask

    // Expected drain: full line, or lower half then upper half when written.
    task automatic m_flush();
        logic [AW-1:0] base;
        base = {m_tag, 6'd0};
        if (m_mask == '0) return;
        if (&m_mask) push(base, m_mask, 1'b1);
        else begin
            if (|m_mask[31:0])  push(base, {32'h0, m_mask[31:0]}, 1'b0);
            if (|m_mask[63:32]) push(base + 32, {m_mask[63:32], 32'h0}, 1'b0);
        end
        m_mask = '0;
    endtask

    // Collector: compare accepted transactions; check fields hold under stall.
    logic           held = 1'b0;
    logic [AW-1:0]  h_addr;
    logic [LB-1:0]  h_mask;
    logic           h_full;
    always @(posedge clk) begin
        if (rst_n) begin
            if (held) begin
                chk(tx_valid && tx_addr == h_addr && tx_mask == h_mask && tx_full == h_full,
                    "R8 hold", {tx_addr, tx_mask[31:0]}, {h_addr, h_mask[31:0]});
            end
            held   = tx_valid && !tx_ready;
            h_addr = tx_addr; h_mask = tx_mask; h_full = tx_full;
            if (tx_valid && tx_ready) begin
                if (rp == wp) begin
                    chk(1'b0, "R6 R10 unexpected tx", {32'h0, tx_addr}, 64'h0);
                end else begin
                    logic dok;
                    dok = 1'b1;
                    for (int i = 0; i < LB; i++)
                        if (q_mask[rp % QD][i] && tx_data[i*8 +: 8] != q_data[rp % QD][i*8 +: 8]) dok = 1'b0;
                    if (q_full[rp % QD]) begin
                        chk(tx_full && tx_addr == q_addr[rp % QD] && tx_mask == q_mask[rp % QD],
                            "R3 full tx", {tx_addr, 31'h0, tx_full}, {q_addr[rp % QD], 32'h1});
                    end else begin
                        chk(!tx_full && tx_addr == q_addr[rp % QD] && tx_mask == q_mask[rp % QD],
                            "R4 R5 masked tx", {tx_addr, tx_mask[63:32] | tx_mask[31:0]},
                            {q_addr[rp % QD], q_mask[rp % QD][63:32] | q_mask[rp % QD][31:0]});
                    end
                    chk(dok, "R2 data under mask", 64'(dok), 64'h1);
                    rp++;
                end
            end
        end
    end

    // Stores must be stalled whenever a transaction is pending.
    always @(negedge clk) begin
        if (rst_n && tx_valid) chk(!st_ready, "R9 stall", 64'(st_ready), 64'h0);
    end

    // Ready pattern: always high, or one cycle in three.
    bit bp_mode = 1'b0;
    int bp_cnt = 0;
    always @(negedge clk) begin
        bp_cnt++;
        tx_ready = bp_mode ? (bp_cnt % 3 == 0) : 1'b1;
    end

    task automatic store(input logic [AW-1:0] a, input logic [63:0] d, input logic [7:0] be);
        if (m_mask != '0 && a[AW-1:6] != m_tag) m_flush();
        if (m_mask == '0) m_tag = a[AW-1:6];
        for (int j = 0; j < WB; j++) begin
            if (be[j]) begin
                m_data[(a[5:3]*8 + j)*8 +: 8] = d[j*8 +: 8];
                m_mask[a[5:3]*8 + j] = 1'b1;
            end
        end
        @(negedge clk);
        st_valid = 1'b1; st_addr = a; st_data = d; st_be = be;
        #1;
        while (!st_ready) begin @(negedge clk); #1; end
        @(posedge clk); #1;
        st_valid = 1'b0;
    endtask

    task automatic flush();
        m_flush();
        @(negedge clk);
        flush_req = 1'b1;
        @(posedge clk); #1;
        flush_req = 1'b0;
        while (tx_valid) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic settle(input string req);
        repeat (3) @(negedge clk);
        chk(rp == wp, req, 64'(rp), 64'(wp));
    endtask

    logic [31:0] lcg = 32'h1234_5678;
    function automatic logic [31:0] rnd();
        lcg = lcg * 32'd1664525 + 32'd1013904223;
        return lcg;
    endfunction

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] pats [4];
        pats[0] = 8'h01; pats[1] = 8'hff; pats[2] = 8'h80; pats[3] = 8'h5a;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!tx_valid, "R1 tx_valid after reset", 64'(tx_valid), 64'h0);
        chk(st_ready, "R1 st_ready after reset", 64'(st_ready), 64'h1);

        // R6 flush of the empty buffer
        flush();
        settle("R6 empty flush no tx");

        // R3 full line
        for (int w = 0; w < 8; w++) store(32'h1000_0000 + w*8, {rnd(), rnd()}, 8'hff);
        flush();
        settle("R3 one full tx");
        // R10 a second flush emits nothing
        flush();
        settle("R10 flush after drain");

        // R4 lower-only and upper-only partial lines
        store(32'h1000_0040, {rnd(), rnd()}, 8'h0f);
        flush();
        settle("R4 lower half only");
        store(32'h1000_0078, {rnd(), rnd()}, 8'hf0);
        flush();
        settle("R4 upper half only");

        // R5 both halves, and R2 overwrite of valid bytes
        store(32'h1000_0088, 64'h1111_1111_1111_1111, 8'hff);
        store(32'h1000_0088, 64'h2222_2222_2222_2222, 8'h3c);
        store(32'h1000_00b0, {rnd(), rnd()}, 8'h81);
        flush();
        settle("R5 lower then upper");

        // R7 store to another line drains the held one first
        store(32'h2000_0000, {rnd(), rnd()}, 8'hff);
        store(32'h2000_0100, {rnd(), rnd()}, 8'h01);
        store(32'h2000_0138, {rnd(), rnd()}, 8'h02);
        flush();
        settle("R7 line change");

        // Sweep: every word slot under several enable patterns, both ready modes.
        for (int m = 0; m < 2; m++) begin
            bp_mode = (m == 1);
            for (int w = 0; w < 8; w++) begin
                for (int p = 0; p < 4; p++) begin
                    store(32'h3000_0000 + w*8, {rnd(), rnd()}, pats[p]);
                    flush();
                end
                settle("R4 sweep slot");
            end
        end

        // R8 full line under backpressure, plus R7 under backpressure
        bp_mode = 1'b1;
        for (int w = 0; w < 8; w++) store(32'h4000_0000 + w*8, {rnd(), rnd()}, 8'hff);
        store(32'h4000_1000, {rnd(), rnd()}, 8'h10);
        flush();
        settle("R8 backpressure drain");

        // Pseudo-random mix over three lines.
        for (int n = 0; n < 400; n++) begin
            logic [31:0] r;
            r = rnd();
            bp_mode = r[20];
            if (r[2:0] == 3'd0) flush();
            else store(32'h5000_0000 + {r[9:8] % 2'd3, 6'd0} + {r[13:11], 3'd0},
                       {rnd(), rnd()}, r[7:3] == 5'd0 ? 8'h00 : (r[16] ? 8'hff : rnd()));
        end
        flush();
        settle("R2 R7 random mix");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule